// File: doc/BRIEF.md
# PSRAM Power-State Command Controller

This block runs the maintenance commands of an external PSRAM: global reset, entry into and exit from half-sleep, and entry into and exit from deep power-down. Firmware starts a command by writing a 1 to its trigger bit. The block asks the burst sequencer for a command slot and waits for the acknowledge. It then times the recovery that the memory needs on the memory clock before it lets ordinary traffic resume. Completion clears the trigger bit, sets a status flag that is cleared when the status is read, and can raise an interrupt.

Exits take two timed phases: a short exit pulse and then a long recovery count. A per-mode bypass bit hands the recovery wait to firmware, so that the memory clock can be stopped. A global reset is followed by a programmable period with chip select held high. Only one command is in flight at a time. While any command is pending or running, the block withdraws its grant so that the sequencer starts no array or mode-register access.

The register bus is reduced to a trigger write strobe with data, a status read strobe, and static configuration inputs held by the register file. The recommended reset values of that register file are: reset opcode 0xFF, reset hold 0x10B, both exit pulse counts 8, half-sleep recovery 0x3416, deep power-down recovery 0x4E20.

Top module: `psram_pwr_ctl`

## Requirements
- R1: After reset, `trigPend`, `statusOut`, `irq` and `cmdReq` are 0 and `accessGnt` is 1.
- R2: The trigger bit positions are: 0 global reset, 1 half-sleep entry, 2 half-sleep exit, 3 deep power-down entry, 4 deep power-down exit. A `trigWr` cycle sets the `trigPend` bits where `trigData` is 1, from the next cycle onward. Bits written as 0 have no effect. A bit clears itself at the clock edge where its operation completes.
- R3: Only one operation is requested at a time. When several triggers are pending, they are served in this order: global reset, deep power-down exit, half-sleep exit, deep power-down entry, half-sleep entry. While `cmdReq` is 1, `cmdKind` carries the bit index from R2 and holds steady until `cmdAck`.
- R4: While a global reset is requested, `cmdOpcode` equals `rstOpcode`; at all other times it is 0. The reset completes max(`rstHold`,1) cycles after the acknowledge edge.
- R5: A half-sleep exit completes max(`hsExitCyc`,1) + max(`hsRecCnt`,1) cycles after its acknowledge edge. A deep power-down exit completes max(`dpdExitCyc`,1) + max(`dpdRecCnt`,1) cycles after its acknowledge edge.
- R6: When `hsIgnore` (or `dpdIgnore`) is 1 at the acknowledge edge, the matching exit completes at that same edge.
- R7: Half-sleep entry and deep power-down entry complete at their acknowledge edge.
- R8: `accessGnt` is 0 whenever any trigger bit is pending or an operation is running.
- R9: Status bits 0 to 4 use the positions of R2, and bit 5 records a `dqsTimeout` pulse. A bit is set on the edge of its event. A `statRd` cycle clears all bits, except that an event in the same cycle leaves its bit set.
- R10: `irq` is 1 exactly when some status bit is 1 and its bit in `intEn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigWr | input | 1 | Trigger register write strobe |
| trigData | input | 5 | Trigger bits to set (write 1 only) |
| statRd | input | 1 | Status read strobe, clears flags |
| dqsTimeout | input | 1 | Pulse from read path: strobe never toggled |
| rstOpcode | input | OPC_W | Global reset command opcode |
| rstHold | input | HOLD_W | Chip-select-high hold after reset, cycles |
| hsExitCyc | input | EXIT_W | Half-sleep exit pulse, cycles |
| hsRecCnt | input | HS_REC_W | Half-sleep recovery, cycles |
| hsIgnore | input | 1 | Skip half-sleep exit timing |
| dpdExitCyc | input | EXIT_W | Deep power-down exit pulse, cycles |
| dpdRecCnt | input | DPD_REC_W | Deep power-down recovery, cycles |
| dpdIgnore | input | 1 | Skip deep power-down exit timing |
| intEn | input | 6 | Per-flag interrupt enables |
| cmdAck | input | 1 | Sequencer has issued the requested command |
| cmdReq | output | 1 | Command slot request |
| cmdKind | output | 3 | Operation index of the request |
| cmdOpcode | output | OPC_W | Opcode for a global reset request, else 0 |
| accessGnt | output | 1 | Ordinary accesses allowed |
| trigPend | output | 5 | Trigger bits readback |
| statusOut | output | 6 | Status flags |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the sequencer raises `cmdAck` only in a cycle where `cmdReq` is 1, and that the configuration inputs stay stable while an operation is running. The bench acknowledges through a responder that watches `cmdReq` and waits a configurable delay, so an unsolicited acknowledge never occurs. It changes counts, bypass bits and the opcode only while the block is idle with no trigger pending. Interrupt enables and status reads are changed at any time, because the requirements allow it.

// File: rtl/psram_pwr_pkg.sv
`timescale 1ns/1ps
package psram_pwr_pkg;
  localparam int NUM_OPS   = 5;
  localparam int NUM_FLAGS = NUM_OPS + 1;

  localparam int OP_GRST    = 0;
  localparam int OP_HS_IN   = 1;
  localparam int OP_HS_OUT  = 2;
  localparam int OP_DPD_IN  = 3;
  localparam int OP_DPD_OUT = 4;

  typedef enum logic [2:0] {
    LD_NONE     = 3'd0,
    LD_HOLD     = 3'd1,
    LD_HS_EXIT  = 3'd2,
    LD_HS_REC   = 3'd3,
    LD_DPD_EXIT = 3'd4,
    LD_DPD_REC  = 3'd5
  } loadSel_e;

  typedef struct packed {
    loadSel_e             loadSel;
    logic                 decr;
    logic [NUM_OPS-1:0]   doneVec;
  } ctlStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_EXIT = 3'd2,
    ST_REC  = 3'd3,
    ST_HOLD = 3'd4
  } state_e;
endpackage

// File: rtl/psram_pwr_dp.sv
`timescale 1ns/1ps
module psram_pwr_dp
  import psram_pwr_pkg::*;
#(
  parameter int HOLD_W    = 9,
  parameter int EXIT_W    = 4,
  parameter int HS_REC_W  = 15,
  parameter int DPD_REC_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobe_t           strb,
  input  logic                 trigWr,
  input  logic [NUM_OPS-1:0]   trigData,
  input  logic [HOLD_W-1:0]    rstHold,
  input  logic [EXIT_W-1:0]    hsExitCyc,
  input  logic [HS_REC_W-1:0]  hsRecCnt,
  input  logic [EXIT_W-1:0]    dpdExitCyc,
  input  logic [DPD_REC_W-1:0] dpdRecCnt,
  input  logic                 statRd,
  input  logic                 dqsTimeout,
  input  logic [NUM_FLAGS-1:0] intEn,
  output logic [NUM_OPS-1:0]   trigPend,
  output logic [NUM_FLAGS-1:0] statusOut,
  output logic                 irq,
  output logic                 cntLast
);
  localparam int MAX_A = (HOLD_W > EXIT_W) ? HOLD_W : EXIT_W;
  localparam int MAX_B = (HS_REC_W > DPD_REC_W) ? HS_REC_W : DPD_REC_W;
  localparam int CNT_W = (MAX_A > MAX_B) ? MAX_A : MAX_B;

  logic [CNT_W-1:0]     cnt;
  logic [CNT_W-1:0]     loadVal;
  logic [NUM_FLAGS-1:0] setVec;

  // Recovery counter: one shared down-counter, reloaded per phase
  always_comb begin
    case (strb.loadSel)
      LD_HOLD:     loadVal = CNT_W'(rstHold);
      LD_HS_EXIT:  loadVal = CNT_W'(hsExitCyc);
      LD_HS_REC:   loadVal = CNT_W'(hsRecCnt);
      LD_DPD_EXIT: loadVal = CNT_W'(dpdExitCyc);
      LD_DPD_REC:  loadVal = CNT_W'(dpdRecCnt);
      default:     loadVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        cnt <= '0;
    else if (strb.loadSel != LD_NONE) cnt <= loadVal;
    else if (strb.decr)               cnt <= cnt - CNT_W'(1);
  end

  // A loaded count of 0 or 1 both mean a single-cycle phase
  assign cntLast = (cnt <= CNT_W'(1));

  // Self-clearing trigger bits: completion beats a same-cycle write
  for (genvar i = 0; i < NUM_OPS; i++) begin : g_trig
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 trigPend[i] <= 1'b0;
      else if (strb.doneVec[i])  trigPend[i] <= 1'b0;
      else if (trigWr && trigData[i]) trigPend[i] <= 1'b1;
    end
  end

  // Read-to-clear flags: a new event in the read cycle survives
  assign setVec = {dqsTimeout, strb.doneVec};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          statusOut[i] <= 1'b0;
      else if (setVec[i]) statusOut[i] <= 1'b1;
      else if (statRd)    statusOut[i] <= 1'b0;
    end
  end

  assign irq = |(statusOut & intEn);
endmodule

// File: rtl/psram_pwr_fsm.sv
`timescale 1ns/1ps
module psram_pwr_fsm
  import psram_pwr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_OPS-1:0] trigPend,
  input  logic               cmdAck,
  input  logic               hsIgnore,
  input  logic               dpdIgnore,
  input  logic               cntLast,
  output ctlStrobe_t         strb,
  output logic               cmdReq,
  output logic [2:0]         cmdKind,
  output logic               busy
);
  // Service order, highest first
  localparam int PRIO [NUM_OPS] = '{OP_GRST, OP_DPD_OUT, OP_HS_OUT, OP_DPD_IN, OP_HS_IN};

  state_e     state, nxtState;
  logic [2:0] curOp, nxtOp;
  logic       finish;

  always_comb begin
    strb     = '0;
    nxtState = state;
    nxtOp    = curOp;
    finish   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (|trigPend) begin
          for (int k = NUM_OPS - 1; k >= 0; k--) begin
            if (trigPend[PRIO[k]]) nxtOp = 3'(PRIO[k]);
          end
          nxtState = ST_REQ;
        end
      end
      ST_REQ: begin
        if (cmdAck) begin
          if (curOp == 3'(OP_GRST)) begin
            strb.loadSel = LD_HOLD;
            nxtState     = ST_HOLD;
          end else if (curOp == 3'(OP_HS_OUT) && !hsIgnore) begin
            strb.loadSel = LD_HS_EXIT;
            nxtState     = ST_EXIT;
          end else if (curOp == 3'(OP_DPD_OUT) && !dpdIgnore) begin
            strb.loadSel = LD_DPD_EXIT;
            nxtState     = ST_EXIT;
          end else begin
            finish = 1'b1;
          end
        end
      end
      ST_EXIT: begin
        if (cntLast) begin
          if (curOp == 3'(OP_HS_OUT)) strb.loadSel = LD_HS_REC;
          else                        strb.loadSel = LD_DPD_REC;
          nxtState = ST_REC;
        end else begin
          strb.decr = 1'b1;
        end
      end
      ST_REC, ST_HOLD: begin
        if (cntLast) finish    = 1'b1;
        else         strb.decr = 1'b1;
      end
      default: nxtState = ST_IDLE;
    endcase
    if (finish) begin
      strb.doneVec = NUM_OPS'(1) << curOp;
      nxtState     = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      curOp <= '0;
    end else begin
      state <= nxtState;
      curOp <= nxtOp;
    end
  end

  assign cmdReq  = (state == ST_REQ);
  assign cmdKind = curOp;
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/psram_pwr_ctl.sv
`timescale 1ns/1ps
module psram_pwr_ctl
  import psram_pwr_pkg::*;
#(
  parameter int OPC_W     = 8,
  parameter int HOLD_W    = 9,
  parameter int EXIT_W    = 4,
  parameter int HS_REC_W  = 15,
  parameter int DPD_REC_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 trigWr,
  input  logic [4:0]           trigData,
  input  logic                 statRd,
  input  logic                 dqsTimeout,
  input  logic [OPC_W-1:0]     rstOpcode,
  input  logic [HOLD_W-1:0]    rstHold,
  input  logic [EXIT_W-1:0]    hsExitCyc,
  input  logic [HS_REC_W-1:0]  hsRecCnt,
  input  logic                 hsIgnore,
  input  logic [EXIT_W-1:0]    dpdExitCyc,
  input  logic [DPD_REC_W-1:0] dpdRecCnt,
  input  logic                 dpdIgnore,
  input  logic [5:0]           intEn,
  input  logic                 cmdAck,
  output logic                 cmdReq,
  output logic [2:0]           cmdKind,
  output logic [OPC_W-1:0]     cmdOpcode,
  output logic                 accessGnt,
  output logic [4:0]           trigPend,
  output logic [5:0]           statusOut,
  output logic                 irq
);
  ctlStrobe_t strb;
  logic       cntLast;
  logic       busy;

  psram_pwr_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .trigPend  (trigPend),
    .cmdAck    (cmdAck),
    .hsIgnore  (hsIgnore),
    .dpdIgnore (dpdIgnore),
    .cntLast   (cntLast),
    .strb      (strb),
    .cmdReq    (cmdReq),
    .cmdKind   (cmdKind),
    .busy      (busy)
  );

  psram_pwr_dp #(
    .HOLD_W    (HOLD_W),
    .EXIT_W    (EXIT_W),
    .HS_REC_W  (HS_REC_W),
    .DPD_REC_W (DPD_REC_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .trigWr     (trigWr),
    .trigData   (trigData),
    .rstHold    (rstHold),
    .hsExitCyc  (hsExitCyc),
    .hsRecCnt   (hsRecCnt),
    .dpdExitCyc (dpdExitCyc),
    .dpdRecCnt  (dpdRecCnt),
    .statRd     (statRd),
    .dqsTimeout (dqsTimeout),
    .intEn      (intEn),
    .trigPend   (trigPend),
    .statusOut  (statusOut),
    .irq        (irq),
    .cntLast    (cntLast)
  );

  assign accessGnt = !busy && (trigPend == '0);
  assign cmdOpcode = (cmdReq && cmdKind == 3'(OP_GRST)) ? rstOpcode : '0;
endmodule

// File: rtl/psram_pwr_chk.sv
`timescale 1ns/1ps
module psram_pwr_chk
  import psram_pwr_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       cmdAck,
  input logic       cmdReq,
  input logic [2:0] cmdKind,
  input logic       accessGnt,
  input logic [4:0] trigPend,
  input logic [5:0] statusOut,
  input logic       statRd,
  input logic       dqsTimeout,
  input logic       irq
);
  // Input assumption: the sequencer acknowledges only a live request (R3)
  p_ack_in_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdAck |-> cmdReq);

  p_kind_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdReq |-> (cmdKind < 3'(NUM_OPS)));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReq && !cmdAck) |=> (cmdReq && $stable(cmdKind)));

  p_no_gnt_in_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmdReq |-> !accessGnt);

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_clr
    p_clear_sets_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
      $fell(trigPend[i]) |-> statusOut[i]);
  end

  p_read_clears_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && !dqsTimeout && accessGnt) |=> (statusOut == '0));

  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusOut != '0));
endmodule

bind psram_pwr_ctl psram_pwr_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .cmdAck     (cmdAck),
  .cmdReq     (cmdReq),
  .cmdKind    (cmdKind),
  .accessGnt  (accessGnt),
  .trigPend   (trigPend),
  .statusOut  (statusOut),
  .statRd     (statRd),
  .dqsTimeout (dqsTimeout),
  .irq        (irq)
);

// File: tb/psram_pwr_ctl_tb_top.sv
`timescale 1ns/1ps
module psram_pwr_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trigWr = 1'b0;
  logic [4:0]  trigData = '0;
  logic        statRd = 1'b0;
  logic        dqsTimeout = 1'b0;
  logic [7:0]  rstOpcode = 8'hFF;
  logic [8:0]  rstHold = 9'd5;
  logic [3:0]  hsExitCyc = 4'd3;
  logic [14:0] hsRecCnt = 15'd7;
  logic        hsIgnore = 1'b0;
  logic [3:0]  dpdExitCyc = 4'd2;
  logic [15:0] dpdRecCnt = 16'd9;
  logic        dpdIgnore = 1'b0;
  logic [5:0]  intEn = 6'h3F;
  logic        cmdAck = 1'b0;
  logic        cmdReq;
  logic [2:0]  cmdKind;
  logic [7:0]  cmdOpcode;
  logic        accessGnt;
  logic [4:0]  trigPend;
  logic [5:0]  statusOut;
  logic        irq;

  always #2.5 clk = ~clk;

  psram_pwr_ctl dut_i (
    .clk(clk), .rstN(rstN), .trigWr(trigWr), .trigData(trigData),
    .statRd(statRd), .dqsTimeout(dqsTimeout), .rstOpcode(rstOpcode),
    .rstHold(rstHold), .hsExitCyc(hsExitCyc), .hsRecCnt(hsRecCnt),
    .hsIgnore(hsIgnore), .dpdExitCyc(dpdExitCyc), .dpdRecCnt(dpdRecCnt),
    .dpdIgnore(dpdIgnore), .intEn(intEn), .cmdAck(cmdAck), .cmdReq(cmdReq),
    .cmdKind(cmdKind), .cmdOpcode(cmdOpcode), .accessGnt(accessGnt),
    .trigPend(trigPend), .statusOut(statusOut), .irq(irq)
  );

  int nChecks = 0;
  int nErr = 0;
  int cyc = 0;
  bit finished = 1'b0;
  localparam int ORDER [5] = '{0, 4, 2, 3, 1};

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int atLeast1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [4:0] mTrig = '0;
  logic [5:0] mFlag = '0;
  int mPhase = 0;   // 0 idle, 1 request, 2 exit pulse, 3 recovery, 4 reset hold
  int mOp = 0;
  int mRemain = 0;

  always @(posedge clk) begin
    int doneOp;
    logic [5:0] setV;
    cyc <= cyc + 1;
    doneOp = -1;
    if (!rstN) begin
      mTrig = '0; mFlag = '0; mPhase = 0; mOp = 0; mRemain = 0;
    end else begin
      case (mPhase)
        0: if (mTrig != 0) begin
             for (int k = 4; k >= 0; k--) if (mTrig[ORDER[k]]) mOp = ORDER[k];
             mPhase = 1;
           end
        1: if (cmdAck) begin
             if (mOp == 0) begin mRemain = atLeast1(int'(rstHold)); mPhase = 4; end
             else if (mOp == 2 && !hsIgnore) begin mRemain = atLeast1(int'(hsExitCyc)); mPhase = 2; end
             else if (mOp == 4 && !dpdIgnore) begin mRemain = atLeast1(int'(dpdExitCyc)); mPhase = 2; end
             else doneOp = mOp;
           end
        2: begin
             mRemain--;
             if (mRemain == 0) begin
               mRemain = (mOp == 2) ? atLeast1(int'(hsRecCnt)) : atLeast1(int'(dpdRecCnt));
               mPhase = 3;
             end
           end
        default: begin
             mRemain--;
             if (mRemain == 0) doneOp = mOp;
           end
      endcase
      setV = {dqsTimeout, 5'b0};
      if (trigWr) mTrig = mTrig | trigData;
      if (doneOp >= 0) begin
        mTrig[doneOp] = 1'b0;
        setV[doneOp] = 1'b1;
        mPhase = 0;
      end
      mFlag = statRd ? setV : (mFlag | setV);
    end
  end

  // Cycle-by-cycle comparison, mid-cycle
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(trigPend == mTrig, "R2 trigPend", trigPend, mTrig);
      chk(cmdReq == (mPhase == 1), "R3 cmdReq", cmdReq, mPhase == 1);
      if (mPhase == 1) chk(cmdKind == 3'(mOp), "R3 cmdKind", cmdKind, mOp);
      chk(cmdOpcode == ((mPhase == 1 && mOp == 0) ? rstOpcode : 8'h00), "R4 cmdOpcode",
          cmdOpcode, (mPhase == 1 && mOp == 0) ? rstOpcode : 8'h00);
      chk(accessGnt == (mPhase == 0 && mTrig == 0), "R8 accessGnt", accessGnt,
          mPhase == 0 && mTrig == 0);
      chk(statusOut == mFlag, "R9 statusOut", statusOut, mFlag);
      chk(irq == |(mFlag & intEn), "R10 irq", irq, |(mFlag & intEn));
    end
  end

  // ---------------- sequencer responder ----------------
  int ackDelay = 1;
  int reqAge = 0;
  always @(posedge clk) begin
    #1;
    if (!cmdReq) begin
      reqAge = 0;
      cmdAck = 1'b0;
    end else begin
      cmdAck = (reqAge >= ackDelay);
      reqAge++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic setTrig(input logic [4:0] d);
    trigWr = 1'b1; trigData = d;
    tick();
    trigWr = 1'b0; trigData = '0;
  endtask

  task automatic clearFlags();
    statRd = 1'b1;
    tick();
    statRd = 1'b0;
  endtask

  task automatic measure(input int b, input int expLat, input string tag);
    int ackEdge = -1;
    int doneEdge = -1;
    int guard = 0;
    clearFlags();
    setTrig(5'(1 << b));
    while (doneEdge < 0 && guard < 60000) begin
      if (cmdAck && ackEdge < 0) ackEdge = cyc + 1;
      if (statusOut[b]) doneEdge = cyc;
      else tick();
      guard++;
    end
    chk(ackEdge >= 0 && doneEdge >= 0 && (doneEdge - ackEdge) == expLat, tag,
        doneEdge - ackEdge, expLat);
    tick();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nErr++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    int got [5];
    int n;
    repeat (3) @(posedge clk);
    #2;
    rstN = 1'b1;
    tick();
    // R1 reset state
    chk(trigPend == 0 && statusOut == 0 && !irq && !cmdReq, "R1 reset outputs", {trigPend, statusOut}, 0);
    chk(accessGnt == 1'b1, "R1 reset grant", accessGnt, 1);

    // R2 zero writes have no effect
    setTrig(5'b0);
    tick();
    chk(trigPend == 0 && accessGnt, "R2 zero write ignored", trigPend, 0);

    // Timed operations with small counts
    measure(0, 5, "R4 reset hold latency");
    measure(2, 3 + 7, "R5 half-sleep exit latency");
    measure(4, 2 + 9, "R5 deep power-down exit latency");
    measure(1, 0, "R7 half-sleep entry latency");
    measure(3, 0, "R7 deep power-down entry latency");

    // Boundaries: counts of 0 behave as 1
    rstHold = 9'd0; hsExitCyc = 4'd0; hsRecCnt = 15'd1;
    tick();
    measure(0, 1, "R4 zero hold latency");
    measure(2, 2, "R5 zero exit pulse latency");

    // Bypass bits
    hsIgnore = 1'b1; dpdIgnore = 1'b1;
    tick();
    measure(2, 0, "R6 half-sleep bypass latency");
    measure(4, 0, "R6 deep power-down bypass latency");
    hsIgnore = 1'b0; dpdIgnore = 1'b0;
    rstHold = 9'd4; hsExitCyc = 4'd2; hsRecCnt = 15'd3;
    ackDelay = 2;
    tick();

    // R3 priority with all triggers at once; R8 grant drops
    clearFlags();
    setTrig(5'b11111);
    chk(accessGnt == 1'b0, "R8 grant low while pending", accessGnt, 0);
    n = 0;
    for (int g = 0; g < 2000 && n < 5; g++) begin
      if (cmdAck) begin got[n] = int'(cmdKind); n++; end
      tick();
    end
    for (int i = 0; i < 5; i++) chk(n == 5 && got[i] == ORDER[i], "R3 service order", got[i], ORDER[i]);
    repeat (30) tick();
    chk(statusOut[4:0] == 5'b11111 && accessGnt, "R2 all triggers done", statusOut, 31);

    // R9 read and event in the same cycle
    clearFlags();
    dqsTimeout = 1'b1; statRd = 1'b1;
    tick();
    dqsTimeout = 1'b0; statRd = 1'b0;
    chk(statusOut == 6'b100000, "R9 timeout survives read", statusOut, 32);
    clearFlags();
    chk(statusOut == 0, "R9 read clears", statusOut, 0);
    setTrig(5'b00010);
    for (int g = 0; g < 50 && !cmdAck; g++) tick();
    statRd = 1'b1;
    tick();
    statRd = 1'b0;
    chk(statusOut[1] == 1'b1, "R9 completion survives read", statusOut[1], 1);

    // R10 masking
    intEn = 6'b0;
    #1;
    chk(irq == 1'b0, "R10 masked", irq, 0);
    intEn = 6'b000010;
    #1;
    chk(irq == 1'b1, "R10 enabled", irq, 1);
    intEn = 6'b111101;
    #1;
    chk(irq == 1'b0, "R10 other enables", irq, 0);
    intEn = 6'h3F;
    tick();

    // Recommended power-up counts
    rstOpcode = 8'hA5; rstHold = 9'h10B;
    hsExitCyc = 4'd8; hsRecCnt = 15'h3416;
    dpdExitCyc = 4'd8; dpdRecCnt = 16'h4E20;
    ackDelay = 0;
    tick();
    measure(0, 'h10B, "R4 default reset hold");
    measure(2, 8 + 'h3416, "R5 default half-sleep exit");
    measure(4, 8 + 'h4E20, "R5 default deep power-down exit");

    repeat (4) tick();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end
endmodule